// File: doc/BRIEF.md
# Synchronous Burst SRAM with Dual Address Strobes

This block is a single-port synchronous static memory with a burst address sequencer in front of it. Each rising clock edge it looks at two active-low address strobes, an address-advance input, three chip enables, a global write enable, a byte-write enable with one enable per byte lane, and a sleep input. From these it decides whether the edge deselects the part, starts a new read, starts a new write, continues a burst at the next address, or suspends a burst at the current address.

The processor-side strobe always opens a read and only counts when the first chip enable is low. The controller-side strobe opens a read or a write, as the write enables decide. While both strobes are high, the advance input chooses between stepping the two low address bits (linear order, wrapping inside an aligned group of four) and repeating the current address. Reads and writes behave the same way here. Read data is registered. The data bus is modelled as separate input and output ports. An output-enable flag stands in for a tristate driver, and the active-low output enable gates that flag without passing through a register.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset, `dq_oe` is 0 and `rdata` is 0 until the first read.
- R2: The part is selected only when `sel_n_a`=0, `sel_b`=1 and `sel_n_c`=0. A strobe-started cycle with any other combination is a deselect: nothing is written, and `dq_oe` is 0 in the next cycle.
- R3: When `sel_n_a`=1, `cpu_strb_n` is ignored. With `ctl_strb_n`=1 such a cycle continues or suspends the burst. It does not load `addr`.
- R4: A cycle with `cpu_strb_n`=0 and `sel_n_a`=0 always starts a read at `addr`, whatever `gwr_n`, `bwr_n`, `lane_wr_n` or `ctl_strb_n` are.
- R5: A cycle with `ctl_strb_n`=0 that R4 does not claim loads `addr`. It is a write when the write decode of R6 enables any lane, and a read otherwise.
- R6: Write decode: `gwr_n`=0 writes both lanes. Otherwise, `bwr_n`=0 writes each lane whose `lane_wr_n` bit is 0, where lane 0 is data bits 8:0 and lane 1 is bits 17:9. In all other cases the cycle reads.
- R7: With both strobes high and `adv_n`=0, an active access goes to the next burst address. Bits 1:0 count up and wrap from 3 to 0, and the upper address bits keep their loaded value.
- R8: With both strobes high and `adv_n`=1, an active access repeats at the current address. This holds for reads and writes.
- R9: Read data appears on `rdata` in the cycle after the edge that performs the read. `dq_oe` is 1 in that cycle only while `oe_n` is 0, and it follows `oe_n` without a clock.
- R10: While `sleep`=1, no access takes place whatever the other inputs are: nothing is written, and `dq_oe` is 0 in the next cycle.
- R11: In the cycle after a write edge, `dq_oe` is 0 even with `oe_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n_a | input | 1 | Chip enable A, active low, also gates the processor strobe |
| sel_b | input | 1 | Chip enable B, active high |
| sel_n_c | input | 1 | Chip enable C, active low |
| cpu_strb_n | input | 1 | Processor-side address strobe, active low |
| ctl_strb_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write, active low |
| bwr_n | input | 1 | Byte-write enable, active low |
| lane_wr_n | input | 2 | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low, not clocked |
| sleep | input | 1 | Sleep, overrides every other input |
| addr | input | 8 | External address |
| wdata | input | 18 | Write data, two 9-bit lanes |
| rdata | output | 18 | Registered read data |
| dq_oe | output | 1 | High when the data bus would be driven |

## Verification
Some functions compete inside one clock cycle. The two strobes can both be low together, and the write enables can also be low then. A strobe, or a write request, can arrive in the same cycle as sleep. The bench sets up each of these overlaps at addresses whose contents it already knows. It then reads those addresses back through the ports to confirm that the processor strobe won and opened a read, and that sleep blocked the write. For each overlap it also checks the output-enable flag in the cycle after the edge.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_DESEL = 2'd3
    } op_e;
endpackage

// File: rtl/sbs_cycle_decode.sv
module sbs_cycle_decode
    import sbs_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n_a,
    input  logic             sel_b,
    input  logic             sel_n_c,
    input  logic             cpu_strb_n,
    input  logic             ctl_strb_n,
    input  logic             adv_n,
    input  logic             gwr_n,
    input  logic             bwr_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic             sleep,
    input  logic             active_q,
    output op_e              op,
    output logic             load,
    output logic             step,
    output logic [LANES-1:0] wmask
);
    logic             selected;
    logic             start_cpu;
    logic             start_ctl;
    logic [LANES-1:0] wmask_dec;
    logic             wr_dec;

    always_comb begin
        selected  = !sel_n_a && sel_b && !sel_n_c;
        start_cpu = !cpu_strb_n && !sel_n_a;
        start_ctl = !ctl_strb_n && !start_cpu;
        if (!gwr_n)      wmask_dec = '1;
        else if (!bwr_n) wmask_dec = ~lane_wr_n;
        else             wmask_dec = '0;
        wr_dec = |wmask_dec;

        op    = OP_IDLE;
        load  = 1'b0;
        step  = 1'b0;
        wmask = '0;
        if (!sleep) begin
            if (start_cpu || start_ctl) begin
                if (!selected) begin
                    op = OP_DESEL;
                end else begin
                    load = 1'b1;
                    if (start_ctl && wr_dec) begin
                        op    = OP_WRITE;
                        wmask = wmask_dec;
                    end else begin
                        op = OP_READ;
                    end
                end
            end else if (active_q) begin
                step = !adv_n;
                if (wr_dec) begin
                    op    = OP_WRITE;
                    wmask = wmask_dec;
                end else begin
                    op = OP_READ;
                end
            end
        end
    end

    a_r4_cpu_strobe_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !cpu_strb_n && !sel_n_a) |-> (op != OP_WRITE));

    a_r10_sleep_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (op == OP_IDLE && !load && !step));

    a_r6_write_has_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE) |-> (wmask != '0));
endmodule

// File: rtl/sbs_burst_addr.sv
module sbs_burst_addr #(
    parameter int AW = 8,
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ext_addr,
    input  logic          load,
    input  logic          step,
    output logic [AW-1:0] acc_addr
);
    logic [AW-1:0] addr_d, addr_q;
    logic [BW-1:0] low_nx;

    always_comb begin
        low_nx = addr_q[BW-1:0] + 1'b1;
        if (load)      acc_addr = ext_addr;
        else if (step) acc_addr = {addr_q[AW-1:BW], low_nx};
        else           acc_addr = addr_q;
        addr_d = acc_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    a_r7_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (addr_q[AW-1:BW] == $past(addr_q[AW-1:BW])));

    a_r8_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(addr_q));
endmodule

// File: rtl/sbs_mem_core.sv
module sbs_mem_core #(
    parameter int DEPTH  = 256,
    parameter int AW     = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int DW    = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             we,
    input  logic [LANES-1:0] wmask,
    input  logic [DW-1:0]    wdata,
    input  logic             re,
    output logic [DW-1:0]    rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];
        logic [LANE_W-1:0] rd_d, rd_q;

        always_ff @(posedge clk) begin
            if (we && wmask[g]) lane_mem[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        always_comb begin
            rd_d = re ? lane_mem[addr] : rd_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_d;
        end

        assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    parameter int BURST_BITS = 2,
    localparam int AW    = $clog2(DEPTH),
    localparam int DW    = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n_a,
    input  logic             sel_b,
    input  logic             sel_n_c,
    input  logic             cpu_strb_n,
    input  logic             ctl_strb_n,
    input  logic             adv_n,
    input  logic             gwr_n,
    input  logic             bwr_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic             oe_n,
    input  logic             sleep,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             dq_oe
);
    typedef struct packed {
        logic active;
        logic rd_valid;
    } ctl_t;

    ctl_t             st_d, st_q;
    op_e              op;
    logic             load;
    logic             step;
    logic [LANES-1:0] wmask;
    logic [AW-1:0]    acc_addr;

    sbs_cycle_decode #(.LANES(LANES)) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_n_a    (sel_n_a),
        .sel_b      (sel_b),
        .sel_n_c    (sel_n_c),
        .cpu_strb_n (cpu_strb_n),
        .ctl_strb_n (ctl_strb_n),
        .adv_n      (adv_n),
        .gwr_n      (gwr_n),
        .bwr_n      (bwr_n),
        .lane_wr_n  (lane_wr_n),
        .sleep      (sleep),
        .active_q   (st_q.active),
        .op         (op),
        .load       (load),
        .step       (step),
        .wmask      (wmask)
    );

    sbs_burst_addr #(.AW(AW), .BW(BURST_BITS)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_addr (addr),
        .load     (load),
        .step     (step),
        .acc_addr (acc_addr)
    );

    sbs_mem_core #(.DEPTH(DEPTH), .AW(AW), .LANE_W(LANE_W), .LANES(LANES)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (acc_addr),
        .we    (op == OP_WRITE),
        .wmask (wmask),
        .wdata (wdata),
        .re    (op == OP_READ),
        .rdata (rdata)
    );

    always_comb begin
        st_d = st_q;
        st_d.rd_valid = (op == OP_READ);
        case (op)
            OP_DESEL:          st_d.active = 1'b0;
            OP_READ, OP_WRITE: st_d.active = 1'b1;
            default:           st_d.active = st_q.active;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dq_oe = st_q.rd_valid && !oe_n;

    a_r11_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE) |=> !dq_oe);

    a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !ctl_strb_n && !(sel_n_c == 1'b0 && sel_b && !sel_n_a)) |=> !dq_oe);

    a_r10_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !dq_oe);
endmodule

// File: tb/sync_burst_sram_bench.sv
module sync_burst_sram_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n_a, sel_b, sel_n_c;
    logic        cpu_strb_n, ctl_strb_n, adv_n;
    logic        gwr_n, bwr_n, oe_n, sleep;
    logic [1:0]  lane_wr_n;
    logic [7:0]  addr;
    logic [17:0] wdata;
    logic [17:0] rdata;
    logic        dq_oe;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    sync_burst_sram u_sync_burst_sram (
        .clk(clk), .rst_n(rst_n), .sel_n_a(sel_n_a), .sel_b(sel_b), .sel_n_c(sel_n_c),
        .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n), .adv_n(adv_n),
        .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_wr_n(lane_wr_n), .oe_n(oe_n),
        .sleep(sleep), .addr(addr), .wdata(wdata), .rdata(rdata), .dq_oe(dq_oe)
    );

    function automatic logic [17:0] pat(input int a);
        return 18'((a * 7919 + 123) & 18'h3FFFF);
    endfunction

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        sel_n_a = 1'b0; sel_b = 1'b1; sel_n_c = 1'b0;
        cpu_strb_n = 1'b1; ctl_strb_n = 1'b1; adv_n = 1'b1;
        gwr_n = 1'b1; bwr_n = 1'b1; lane_wr_n = 2'b11;
        oe_n = 1'b0; sleep = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic deselect();
        idle(); sel_n_c = 1'b1; ctl_strb_n = 1'b0; step(); idle();
    endtask

    task automatic ctl_write(input int a, input logic [17:0] d);
        idle(); ctl_strb_n = 1'b0; gwr_n = 1'b0; addr = 8'(a); wdata = d;
        step(); idle();
    endtask

    task automatic cpu_read(input int a, input string req, input logic [17:0] exp);
        idle(); cpu_strb_n = 1'b0; addr = 8'(a);
        step(); idle();
        chk(req, rdata, exp);
        chk(req, 18'(dq_oe), 18'd1);
    endtask

    task automatic t_reset();
        idle(); sel_n_c = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 dq_oe", 18'(dq_oe), 18'd0);
        chk("R1 rdata", rdata, 18'd0);
        rst_n = 1'b1;
        @(negedge clk);
        idle();
    endtask

    task automatic t_fill_read();
        for (int a = 0; a < 32; a++) begin
            ctl_write(a, pat(a));
            chk("R11 quiet after write", 18'(dq_oe), 18'd0);
        end
        deselect();
        cpu_read(5, "R9 latency", pat(5));
        oe_n = 1'b1; #1;
        chk("R9 oe_n high", 18'(dq_oe), 18'd0);
        oe_n = 1'b0; #1;
        chk("R9 oe_n low", 18'(dq_oe), 18'd1);
        deselect();
    endtask

    task automatic t_lanes();
        logic [17:0] exp;
        exp = {pat(9)[17:9], 9'h1FF};
        idle(); ctl_strb_n = 1'b0; bwr_n = 1'b0; lane_wr_n = 2'b10;
        addr = 8'd9; wdata = 18'h3FFFF; step(); idle();
        exp = {9'h000, 9'h1FF};
        ctl_strb_n = 1'b0; bwr_n = 1'b0; lane_wr_n = 2'b01;
        addr = 8'd9; wdata = 18'h00000; step(); idle();
        ctl_strb_n = 1'b0; bwr_n = 1'b0; lane_wr_n = 2'b11; addr = 8'd9; wdata = 18'h2AAAA;
        step(); idle();
        chk("R5 ctl read, R6 lanes", rdata, exp);
        chk("R5 ctl read drives", 18'(dq_oe), 18'd1);
        ctl_strb_n = 1'b0; gwr_n = 1'b1; bwr_n = 1'b1; lane_wr_n = 2'b00; addr = 8'd10;
        step(); idle();
        chk("R6 bwr_n high reads", rdata, pat(10));
        deselect();
    endtask

    task automatic t_cpu_priority();
        idle(); cpu_strb_n = 1'b0; ctl_strb_n = 1'b0; gwr_n = 1'b0;
        addr = 8'd3; wdata = 18'h0; step(); idle();
        chk("R4 both strobes read", rdata, pat(3));
        chk("R4 both strobes drive", 18'(dq_oe), 18'd1);
        deselect();
        cpu_read(3, "R4 memory unchanged", pat(3));
        deselect();
    endtask

    task automatic t_burst();
        int seq[4] = '{6, 7, 4, 5};
        cpu_read(6, "R7 burst start", pat(6));
        for (int i = 1; i < 4; i++) begin
            adv_n = 1'b0; step(); idle();
            chk("R7 read advance", rdata, pat(seq[i]));
        end
        deselect();
        idle(); ctl_strb_n = 1'b0; gwr_n = 1'b0; addr = 8'd19; wdata = 18'h11111; step(); idle();
        adv_n = 1'b0; gwr_n = 1'b0; wdata = 18'h22222; step(); idle();
        adv_n = 1'b0; gwr_n = 1'b0; wdata = 18'h33333; step(); idle();
        deselect();
        cpu_read(19, "R7 write start", 18'h11111);
        cpu_read(16, "R7 write wrap", 18'h22222);
        cpu_read(17, "R7 write next", 18'h33333);
        cpu_read(18, "R7 untouched", pat(18));
        deselect();
    endtask

    task automatic t_suspend();
        cpu_read(1, "R8 start", pat(1));
        for (int i = 0; i < 2; i++) begin
            adv_n = 1'b1; step(); idle();
            chk("R8 read repeat", rdata, pat(1));
        end
        adv_n = 1'b0; step(); idle();
        chk("R8 then advance", rdata, pat(2));
        deselect();
        ctl_write(20, 18'h0ABCD);
        adv_n = 1'b1; gwr_n = 1'b0; wdata = 18'h1BEEF; step(); idle();
        deselect();
        cpu_read(20, "R8 write repeat", 18'h1BEEF);
        cpu_read(21, "R8 neighbour kept", pat(21));
        deselect();
    endtask

    task automatic t_cpu_ignored();
        cpu_read(4, "R3 setup", pat(4));
        sel_n_a = 1'b1; cpu_strb_n = 1'b0; adv_n = 1'b0; addr = 8'd30;
        step(); idle();
        chk("R3 strobe ignored, continues", rdata, pat(5));
        sel_n_a = 1'b1; ctl_strb_n = 1'b0; step(); idle();
        chk("R3 ctl deselect", 18'(dq_oe), 18'd0);
    endtask

    task automatic t_deselect();
        idle(); sel_b = 1'b0; ctl_strb_n = 1'b0; gwr_n = 1'b0; addr = 8'd0; wdata = 18'h0;
        step(); idle();
        chk("R2 sel_b low quiet", 18'(dq_oe), 18'd0);
        cpu_read(0, "R2 no write", pat(0));
        sel_n_c = 1'b1; cpu_strb_n = 1'b0; addr = 8'd2; step(); idle();
        chk("R2 sel_n_c high quiet", 18'(dq_oe), 18'd0);
        gwr_n = 1'b0; wdata = 18'h0; step(); idle();
        deselect();
        cpu_read(2, "R2 idle no write", pat(2));
        deselect();
    endtask

    task automatic t_sleep();
        cpu_read(8, "R10 setup", pat(8));
        sleep = 1'b1; ctl_strb_n = 1'b0; gwr_n = 1'b0; addr = 8'd1; wdata = 18'h0;
        step(); idle();
        chk("R10 sleep quiet", 18'(dq_oe), 18'd0);
        cpu_read(1, "R10 no write", pat(1));
        deselect();
    endtask

    initial begin
        t_reset();
        t_fill_read();
        t_lanes();
        t_cpu_priority();
        t_burst();
        t_suspend();
        t_cpu_ignored();
        t_deselect();
        t_sleep();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule